// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Servicer

This block watches a bank of interrupt input lines and decides, pin by pin, when an interrupt message must be sent downstream. Each pin has a configuration entry (vector, destination, destination addressing mode, delivery mode, trigger style and mask). The block keeps the request register that mirrors the lines, a per-pin in-service flag for level-triggered pins, and a per-pin delivered flag for edge-triggered pins.

When pins need service, the lowest-numbered requesting pin is chosen. Its entry is copied into a message register and offered downstream under a valid/ready handshake. When the handshake completes, the downstream side also reports whether at least one destination took the message. For a level-triggered pin that was taken, the in-service flag is set and blocks further messages for that pin. Rewriting the pin's entry clears the flag again.

A state view of the request register hides edge-triggered bits that have already been delivered. This lets saved state be replayed without raising duplicate edges.

Top module: `isr_pin_servicer`

## Requirements
- R1: At each clock edge, every bit of `irr_o` takes the value of its line input, whether or not the pin is masked. A low line clears the bit and produces no message.
- R2: An edge-triggered pin (`cfg_level_i`=0) requests one message when its line is high at a clock edge at which its `irr_o` bit was 0. A line held high requests nothing more.
- R3: A level-triggered pin (`cfg_level_i`=1) requests a message while its `irr_o` bit is 1 and its `rirr_o` bit is 0. No request is made while `rirr_o` is 1.
- R4: A pin's `rirr_o` bit is set only when a handshake completes (`msg_valid_o`=1 and `msg_ready_i`=1) for a level-triggered message of that pin with `msg_accepted_i`=1. A handshake with `msg_accepted_i`=0 leaves it clear, and the pin requests again.
- R5: A pin whose mask bit is 1 is never offered. Reset sets the mask bit of every entry.
- R6: The message outputs carry the vector, destination, addressing mode, delivery mode and trigger style of the granted pin's entry. They are captured in the cycle the grant is made, and `msg_valid_o` rises one cycle after the request becomes visible.
- R7: At most one message is outstanding. While `msg_valid_o`=1 and `msg_ready_i`=0, all message outputs hold their values. A new grant is made only in a cycle with no outstanding message.
- R8: When several pins request together, the lowest pin number is granted first.
- R9: Granting an edge-triggered pin sets its delivered flag, which is cleared by the pin's next rising line. `irr_view_o` equals `irr_o` with the bits of delivered edge-triggered pins forced to 0.
- R10: A configuration write (`cfg_we_i`=1) replaces the entry of pin `cfg_pin_i` and clears its `rirr_o` bit at the same edge. A level-triggered pin whose line is still high then requests through the same priority scan as line-driven requests.
- R11: After reset, `msg_valid_o`, `irr_o`, `irr_view_o` and `rirr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | NUM_PINS | Interrupt line levels, one per pin |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_pin_i | input | PIN_W | Pin whose entry is written |
| cfg_vector_i | input | VEC_W | Vector for the entry |
| cfg_dest_i | input | DEST_W | Destination identifier |
| cfg_logical_i | input | 1 | Destination addressing mode, 1 = logical |
| cfg_dlv_i | input | DLV_W | Delivery mode code |
| cfg_level_i | input | 1 | Trigger style, 1 = level, 0 = edge |
| cfg_mask_i | input | 1 | 1 = pin masked |
| msg_ready_i | input | 1 | Downstream takes the message this cycle |
| msg_accepted_i | input | 1 | With ready: at least one destination took it |
| msg_valid_o | output | 1 | A message is offered |
| msg_pin_o | output | PIN_W | Pin of the offered message |
| msg_vector_o | output | VEC_W | Vector of the offered message |
| msg_dest_o | output | DEST_W | Destination of the offered message |
| msg_logical_o | output | 1 | Addressing mode of the offered message |
| msg_dlv_o | output | DLV_W | Delivery mode of the offered message |
| msg_level_o | output | 1 | Trigger style of the offered message |
| irr_o | output | NUM_PINS | Request register |
| irr_view_o | output | NUM_PINS | Request register with delivered edge bits hidden |
| rirr_o | output | NUM_PINS | Level in-service flags |

## Verification
The bench goes after the in-service flag of a level pin. A delivery that is offered but not taken must leave the flag clear so the pin comes back. A design that set the flag on any handshake would lose that interrupt for good. It holds an edge line high for several cycles, where a design that fired on level instead of on a rise would send repeated messages. It raises two edge pins together to expose a wrong priority order, stalls the handshake to catch message fields that move, and checks that the view hides a delivered edge bit until the line rises again. Last, it rewrites a blocked level pin's entry: a design that failed to clear the flag would never offer the new vector.

// File: rtl/isr_pkg.sv
package isr_pkg;
   parameter int VEC_W  = 8;
   parameter int DEST_W = 8;
   parameter int DLV_W  = 3;

   typedef struct packed {
      logic [VEC_W-1:0]  vector;
      logic [DEST_W-1:0] dest;
      logic              logical;
      logic [DLV_W-1:0]  dlv;
      logic              level;
      logic              mask;
   } isr_entry_t;

   localparam isr_entry_t ENTRY_RST = '{vector: '0, dest: '0, logical: 1'b0,
                                        dlv: '0, level: 1'b0, mask: 1'b1};
endpackage

// File: rtl/isr_entry_table.sv
module isr_entry_table
   import isr_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int PIN_W    = $clog2(NUM_PINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [PIN_W-1:0] pin_i,
   input  isr_entry_t       entry_i,
   output isr_entry_t       entries_o [NUM_PINS],
   output logic [NUM_PINS-1:0] wr_oh_o
);
   for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
      assign wr_oh_o[g] = we_i && (pin_i == PIN_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)          entries_o[g] <= ENTRY_RST;
         else if (wr_oh_o[g]) entries_o[g] <= entry_i;
      end
   end
endmodule

// File: rtl/isr_pin_track.sv
module isr_pin_track #(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] line_i,
   input  logic [NUM_PINS-1:0] lvl_i,
   input  logic [NUM_PINS-1:0] mask_i,
   input  logic [NUM_PINS-1:0] gnt_oh_i,
   input  logic [NUM_PINS-1:0] inflight_oh_i,
   input  logic [NUM_PINS-1:0] set_rirr_oh_i,
   input  logic [NUM_PINS-1:0] clr_rirr_oh_i,
   output logic [NUM_PINS-1:0] irr_o,
   output logic [NUM_PINS-1:0] rirr_o,
   output logic [NUM_PINS-1:0] deliv_o,
   output logic [NUM_PINS-1:0] req_o
);
   logic [NUM_PINS-1:0] pend_q;
   logic [NUM_PINS-1:0] rise;

   assign rise = line_i & ~irr_o;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      // level pins request from state, edge pins from a latched rise
      assign req_o[g] = lvl_i[g]
                      ? (irr_o[g] & ~rirr_o[g] & ~mask_i[g] & ~inflight_oh_i[g])
                      : (pend_q[g] & ~mask_i[g]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irr_o[g]   <= 1'b0;
            pend_q[g]  <= 1'b0;
            rirr_o[g]  <= 1'b0;
            deliv_o[g] <= 1'b0;
         end else begin
            irr_o[g] <= line_i[g];
            // a fresh rise outranks a grant made in the same cycle
            if (rise[g] && !lvl_i[g] && !mask_i[g]) pend_q[g] <= 1'b1;
            else if (gnt_oh_i[g] || mask_i[g] || lvl_i[g]) pend_q[g] <= 1'b0;
            if (rise[g] && !lvl_i[g])          deliv_o[g] <= 1'b0;
            else if (gnt_oh_i[g] && !lvl_i[g]) deliv_o[g] <= 1'b1;
            if (clr_rirr_oh_i[g])      rirr_o[g] <= 1'b0;
            else if (set_rirr_oh_i[g]) rirr_o[g] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/isr_lowest_pick.sv
module isr_lowest_pick #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  gnt_oh_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
      any_o    = |req_i;
      gnt_oh_o = any_o ? (N'(1) << idx_o) : '0;
   end
endmodule

// File: rtl/isr_pin_servicer.sv
module isr_pin_servicer
   import isr_pkg::*;
#(
   parameter int NUM_PINS = 8,
   localparam int PIN_W   = $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] line_i,
   input  logic                cfg_we_i,
   input  logic [PIN_W-1:0]    cfg_pin_i,
   input  logic [VEC_W-1:0]    cfg_vector_i,
   input  logic [DEST_W-1:0]   cfg_dest_i,
   input  logic                cfg_logical_i,
   input  logic [DLV_W-1:0]    cfg_dlv_i,
   input  logic                cfg_level_i,
   input  logic                cfg_mask_i,
   input  logic                msg_ready_i,
   input  logic                msg_accepted_i,
   output logic                msg_valid_o,
   output logic [PIN_W-1:0]    msg_pin_o,
   output logic [VEC_W-1:0]    msg_vector_o,
   output logic [DEST_W-1:0]   msg_dest_o,
   output logic                msg_logical_o,
   output logic [DLV_W-1:0]    msg_dlv_o,
   output logic                msg_level_o,
   output logic [NUM_PINS-1:0] irr_o,
   output logic [NUM_PINS-1:0] irr_view_o,
   output logic [NUM_PINS-1:0] rirr_o
);
   if (NUM_PINS < 2 || NUM_PINS > 64) begin : g_bad_pins
      $error("isr_pin_servicer: NUM_PINS must lie in 2..64");
   end
   if (VEC_W < 1 || DEST_W < 1 || DLV_W < 1) begin : g_bad_widths
      $error("isr_pin_servicer: field widths must be positive");
   end

   isr_entry_t          entries [NUM_PINS];
   isr_entry_t          cfg_entry;
   isr_entry_t          msg_q;
   logic [NUM_PINS-1:0] wr_oh, lvl_v, mask_v, deliv, req, pick_req;
   logic [NUM_PINS-1:0] gnt_oh, inflight_oh, set_rirr_oh;
   logic [PIN_W-1:0]    gnt_idx;
   logic                gnt_any, done;

   assign cfg_entry = '{vector: cfg_vector_i, dest: cfg_dest_i, logical: cfg_logical_i,
                        dlv: cfg_dlv_i, level: cfg_level_i, mask: cfg_mask_i};

   isr_entry_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_table (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .pin_i(cfg_pin_i),
      .entry_i(cfg_entry), .entries_o(entries), .wr_oh_o(wr_oh));

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_vec
      assign lvl_v[g]  = entries[g].level;
      assign mask_v[g] = entries[g].mask;
   end

   assign done        = msg_valid_o && msg_ready_i;
   assign inflight_oh = msg_valid_o ? (NUM_PINS'(1) << msg_pin_o) : '0;
   assign set_rirr_oh = (done && msg_accepted_i && msg_q.level) ? inflight_oh : '0;

   isr_pin_track #(.NUM_PINS(NUM_PINS)) u_track (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .lvl_i(lvl_v), .mask_i(mask_v),
      .gnt_oh_i(gnt_oh), .inflight_oh_i(inflight_oh), .set_rirr_oh_i(set_rirr_oh),
      .clr_rirr_oh_i(wr_oh), .irr_o(irr_o), .rirr_o(rirr_o), .deliv_o(deliv),
      .req_o(req));

   // grants only while the message slot is empty
   assign pick_req = msg_valid_o ? '0 : req;

   isr_lowest_pick #(.N(NUM_PINS), .IW(PIN_W)) u_pick (
      .req_i(pick_req), .gnt_oh_o(gnt_oh), .idx_o(gnt_idx), .any_o(gnt_any));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid_o <= 1'b0;
         msg_pin_o   <= '0;
         msg_q       <= ENTRY_RST;
      end else if (gnt_any) begin
         msg_valid_o <= 1'b1;
         msg_pin_o   <= gnt_idx;
         msg_q       <= entries[gnt_idx];
      end else if (done) begin
         msg_valid_o <= 1'b0;
      end
   end

   assign msg_vector_o  = msg_q.vector;
   assign msg_dest_o    = msg_q.dest;
   assign msg_logical_o = msg_q.logical;
   assign msg_dlv_o     = msg_q.dlv;
   assign msg_level_o   = msg_q.level;
   assign irr_view_o    = irr_o & ~(deliv & ~lvl_v);

   // R7: a stalled message keeps every field
   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_pin_o) &&
         $stable(msg_vector_o) && $stable(msg_dest_o) && $stable(msg_dlv_o) &&
         $stable(msg_level_o) && $stable(msg_logical_o)));

   // R5: the table's mask is honoured by the picker
   a_r5_no_masked_grant: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_any |-> !entries[gnt_idx].mask);

   // R8: nothing below the granted pin was requesting
   a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_any |-> ((gnt_oh - NUM_PINS'(1)) & req) == '0);

   // R3: a level pin in service is never granted
   a_r3_rirr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_oh & rirr_o & lvl_v) == '0);

   // R4: in-service flag rises only after an accepted handshake of that pin
   for (genvar g = 0; g < NUM_PINS; g++) begin : g_a_r4
      a_r4_rirr_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rirr_o[g]) |-> $past(msg_valid_o && msg_ready_i && msg_accepted_i &&
                                    msg_level_o && (msg_pin_o == PIN_W'(g))));
   end
endmodule

// File: tb/tb_isr_pin_servicer.sv
module tb_isr_pin_servicer;
   import isr_pkg::*;
   localparam int NP = 8;
   localparam int PW = $clog2(NP);
   localparam int NV = 23;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] line = '0;
   logic cfg_we = 1'b0, cfg_logical = 1'b0, cfg_level = 1'b0, cfg_mask = 1'b1;
   logic [PW-1:0] cfg_pin = '0;
   logic [VEC_W-1:0] cfg_vector = '0;
   logic [DEST_W-1:0] cfg_dest = '0;
   logic [DLV_W-1:0] cfg_dlv = '0;
   logic rdy = 1'b0, acc = 1'b0;
   logic msg_valid, msg_logical, msg_level;
   logic [PW-1:0] msg_pin;
   logic [VEC_W-1:0] msg_vector;
   logic [DEST_W-1:0] msg_dest;
   logic [DLV_W-1:0] msg_dlv;
   logic [NP-1:0] irr, irr_view, rirr;
   int nchk = 0, nfail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   isr_pin_servicer #(.NUM_PINS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .line_i(line), .cfg_we_i(cfg_we), .cfg_pin_i(cfg_pin),
      .cfg_vector_i(cfg_vector), .cfg_dest_i(cfg_dest), .cfg_logical_i(cfg_logical),
      .cfg_dlv_i(cfg_dlv), .cfg_level_i(cfg_level), .cfg_mask_i(cfg_mask),
      .msg_ready_i(rdy), .msg_accepted_i(acc), .msg_valid_o(msg_valid),
      .msg_pin_o(msg_pin), .msg_vector_o(msg_vector), .msg_dest_o(msg_dest),
      .msg_logical_o(msg_logical), .msg_dlv_o(msg_dlv), .msg_level_o(msg_level),
      .irr_o(irr), .irr_view_o(irr_view), .rirr_o(rirr));

   // {line, ready, accepted, exp_valid, exp_pin, exp_irr, exp_view, exp_rirr}
   localparam logic [37:0] VEC [NV] = '{
      {8'h01,1'b0,1'b0,1'b0,3'd0,8'h01,8'h01,8'h00}, // R2 rise latched
      {8'h01,1'b0,1'b0,1'b1,3'd0,8'h01,8'h00,8'h00}, // R2 R9 edge grant
      {8'h01,1'b1,1'b1,1'b0,3'd0,8'h01,8'h00,8'h00},
      {8'h01,1'b0,1'b0,1'b0,3'd0,8'h01,8'h00,8'h00}, // R2 held high, no repeat
      {8'h02,1'b0,1'b0,1'b0,3'd0,8'h02,8'h02,8'h00}, // R1 low clears
      {8'h02,1'b0,1'b0,1'b1,3'd1,8'h02,8'h02,8'h00}, // R3 level grant
      {8'h02,1'b0,1'b0,1'b1,3'd1,8'h02,8'h02,8'h00}, // R7 stall
      {8'h02,1'b1,1'b1,1'b0,3'd0,8'h02,8'h02,8'h02}, // R4 accepted
      {8'h02,1'b0,1'b0,1'b0,3'd0,8'h02,8'h02,8'h02}, // R3 blocked
      {8'h06,1'b0,1'b0,1'b0,3'd0,8'h06,8'h06,8'h02}, // R5 masked rise
      {8'h06,1'b0,1'b0,1'b0,3'd0,8'h06,8'h06,8'h02}, // R5
      {8'h0E,1'b0,1'b0,1'b0,3'd0,8'h0E,8'h0E,8'h02},
      {8'h0E,1'b0,1'b0,1'b1,3'd3,8'h0E,8'h0E,8'h02}, // R3
      {8'h0E,1'b1,1'b0,1'b0,3'd0,8'h0E,8'h0E,8'h02}, // R4 not accepted
      {8'h0E,1'b0,1'b0,1'b1,3'd3,8'h0E,8'h0E,8'h02}, // R4 retry
      {8'h0E,1'b1,1'b1,1'b0,3'd0,8'h0E,8'h0E,8'h0A}, // R4
      {8'h0E,1'b0,1'b0,1'b0,3'd0,8'h0E,8'h0E,8'h0A},
      {8'h1F,1'b0,1'b0,1'b0,3'd0,8'h1F,8'h1F,8'h0A}, // R9 new rise unhides
      {8'h1F,1'b0,1'b0,1'b1,3'd0,8'h1F,8'h1E,8'h0A}, // R8 pin0 first
      {8'h1F,1'b1,1'b1,1'b0,3'd0,8'h1F,8'h1E,8'h0A},
      {8'h1F,1'b0,1'b0,1'b1,3'd4,8'h1F,8'h0E,8'h0A}, // R8 then pin4
      {8'h1F,1'b1,1'b1,1'b0,3'd0,8'h1F,8'h0E,8'h0A},
      {8'h00,1'b0,1'b0,1'b0,3'd0,8'h00,8'h00,8'h0A}  // R1
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input int pin, input logic [7:0] vec, input logic lvl, input logic msk);
      @(negedge clk);
      cfg_we = 1'b1; cfg_pin = PW'(pin); cfg_vector = vec; cfg_dest = 8'h10;
      cfg_logical = 1'b0; cfg_dlv = '0; cfg_level = lvl; cfg_mask = msk;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 valid", 32'(msg_valid), 0);
      chk("R11 irr", 32'(irr), 0);
      chk("R11 view", 32'(irr_view), 0);
      chk("R11 rirr", 32'(rirr), 0);
      // R5 every pin masked from reset; R1 irr follows lines anyway
      line = 8'hFF;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R5 reset mask valid", 32'(msg_valid), 0);
         chk("R1 irr masked", 32'(irr), 32'hFF);
      end
      line = 8'h00;
      @(negedge clk);
      chk("R1 irr clears", 32'(irr), 0);
      cfg(0, 8'h20, 1'b0, 1'b0);
      cfg(1, 8'h21, 1'b1, 1'b0);
      cfg(2, 8'h22, 1'b0, 1'b1);
      cfg(3, 8'h23, 1'b1, 1'b0);
      cfg(4, 8'h24, 1'b0, 1'b0);
      chk("R5 idle after cfg", 32'(msg_valid), 0);

      for (int v = 0; v < NV; v++) begin
         line = VEC[v][37:30]; rdy = VEC[v][29]; acc = VEC[v][28];
         @(negedge clk);
         chk($sformatf("R2/R3/R7 vec%0d valid", v), 32'(msg_valid), 32'(VEC[v][27]));
         if (VEC[v][27]) chk($sformatf("R8 vec%0d pin", v), 32'(msg_pin), 32'(VEC[v][26:24]));
         chk($sformatf("R1 vec%0d irr", v), 32'(irr), 32'(VEC[v][23:16]));
         chk($sformatf("R9 vec%0d view", v), 32'(irr_view), 32'(VEC[v][15:8]));
         chk($sformatf("R4 vec%0d rirr", v), 32'(rirr), 32'(VEC[v][7:0]));
      end
      rdy = 1'b0; acc = 1'b0;

      // R10: rewrite a blocked level pin, flag clears, new entry goes out
      line = 8'h02;
      @(negedge clk);
      chk("R3 pin1 blocked", 32'(msg_valid), 0);
      cfg_we = 1'b1; cfg_pin = 3'd1; cfg_vector = 8'h55; cfg_dest = 8'h9A;
      cfg_logical = 1'b1; cfg_dlv = 3'd5; cfg_level = 1'b1; cfg_mask = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R10 rirr cleared", 32'(rirr), 32'h08);
      chk("R10 no grant yet", 32'(msg_valid), 0);
      @(negedge clk);
      chk("R10 valid", 32'(msg_valid), 1);
      chk("R6 pin", 32'(msg_pin), 1);
      chk("R6 vector", 32'(msg_vector), 32'h55);
      chk("R6 dest", 32'(msg_dest), 32'h9A);
      chk("R6 logical", 32'(msg_logical), 1);
      chk("R6 dlv", 32'(msg_dlv), 5);
      chk("R6 level", 32'(msg_level), 1);
      repeat (2) @(negedge clk);
      chk("R7 held valid", 32'(msg_valid), 1);
      chk("R7 held vector", 32'(msg_vector), 32'h55);
      rdy = 1'b1; acc = 1'b1;
      @(negedge clk);
      rdy = 1'b0; acc = 1'b0;
      chk("R4 accepted again", 32'(rirr), 32'h0A);
      chk("R7 slot empty", 32'(msg_valid), 0);
      @(negedge clk);
      chk("R3 blocked again", 32'(msg_valid), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule